// File: doc/BRIEF.md
# Segmented Approximate Adder

This block adds two unsigned operands of parameterised width by cutting them at a chosen split bit. The bits below the split go through an exact ripple-carry chain of their own. The bits above the split go through a second, independent ripple chain. A per-operation mode input decides what happens to the carry leaving the lower chain. In exact mode that carry is fed into the upper chain, so the result is the true sum. In approximate mode the carry is thrown away. This removes the long path through both chains, at the price of an error of exactly 2^SPLIT whenever that carry would have been 1.

The operands, the mode and a valid strobe are captured on one clock edge. The sum and a separate carry-out appear on registered outputs one cycle later. Any carry out of the upper chain is removed from the WIDTH-bit sum and presented on the carry-out port. Designers use it where small, bounded errors are acceptable and a shorter adder is worth having, for example in filter accumulations or error-tolerant datapaths. The mode can change on every operation.

Top module: `seg_approx_adder`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `out_valid`=0, `sum`=0 and `carry_out`=0.
- R2: With `exact_mode`=1, one cycle after an accepted operation `{carry_out, sum}` equals the full (WIDTH+1)-bit sum `opa + opb`.
- R3: In either mode, `sum[SPLIT-1:0]` equals the low SPLIT bits of `opa[SPLIT-1:0] + opb[SPLIT-1:0]`.
- R4: With `exact_mode`=0, `{carry_out, sum[WIDTH-1:SPLIT]}` equals `opa[WIDTH-1:SPLIT] + opb[WIDTH-1:SPLIT]` with no carry-in from the lower field.
- R5: With `exact_mode`=0, the exact sum minus `{carry_out, sum}` is 2^SPLIT when `opa[SPLIT-1:0] + opb[SPLIT-1:0]` reaches 2^SPLIT, and 0 otherwise.
- R6: `out_valid` is `in_valid` delayed by one cycle. A cycle with `in_valid`=0 leaves `sum` and `carry_out` unchanged.
- R7: The mode is taken together with the operands of the same operation. Back-to-back operations with alternating modes each use their own mode.
- R8: For WIDTH=8 and SPLIT=4, the largest approximate-mode error is 16, reached for example by 0x0F+0x01 (gives 0x00, exact 0x10) and 0xFF+0xFF (gives carry 1, sum 0xEE, exact carry 1, sum 0xFE).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are presented this cycle |
| exact_mode | input | 1 | 1 forwards the lower-field carry, 0 drops it |
| opa | input | WIDTH | First unsigned operand |
| opb | input | WIDTH | Second unsigned operand |
| out_valid | output | 1 | Registered result is new this cycle |
| sum | output | WIDTH | Registered WIDTH-bit sum |
| carry_out | output | 1 | Registered carry out of the upper field |

## Verification
The assertions assume that `opa`, `opb` and `exact_mode` are settled at each rising edge where `in_valid` is high. They also assume that reset is held for at least one edge before the first operation. The stimulus drives all inputs only on falling edges, holds reset for several cycles, and then issues operations both in continuous streams and separated by idle cycles. The mode is switched freely between operations so that every mode transition falls inside the checked window.

// File: rtl/sa_pkg.sv
package sa_pkg;

  typedef enum logic {
    MODE_APPROX = 1'b0,
    MODE_EXACT  = 1'b1
  } add_mode_e;

endpackage

// File: rtl/sa_ripple_block.sv
module sa_ripple_block #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);

  logic [W:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s[i]       = a[i] ^ b[i] ^ chain[i];
    assign chain[i+1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
  end

  assign cout = chain[W];

endmodule

// File: rtl/sa_carry_gate.sv
module sa_carry_gate
  import sa_pkg::*;
(
  input  add_mode_e mode,
  input  logic      cy_in,
  output logic      cy_out
);

  always_comb begin
    unique case (mode)
      MODE_EXACT:  cy_out = cy_in;
      MODE_APPROX: cy_out = 1'b0;
      default:     cy_out = 1'b0;
    endcase
  end

endmodule

// File: rtl/seg_approx_adder.sv
module seg_approx_adder
  import sa_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SPLIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             exact_mode,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic             out_valid,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);

  localparam int HI_W = WIDTH - SPLIT;

  add_mode_e        mode;
  logic [SPLIT-1:0] lo_sum;
  logic             lo_cy;
  logic             hi_cin;
  logic [HI_W-1:0]  hi_sum;
  logic             hi_cy;

  assign mode = add_mode_e'(exact_mode);

  sa_ripple_block #(.W(SPLIT)) u_lo (
    .a    (opa[SPLIT-1:0]),
    .b    (opb[SPLIT-1:0]),
    .cin  (1'b0),
    .s    (lo_sum),
    .cout (lo_cy)
  );

  sa_carry_gate u_gate (
    .mode   (mode),
    .cy_in  (lo_cy),
    .cy_out (hi_cin)
  );

  sa_ripple_block #(.W(HI_W)) u_hi (
    .a    (opa[WIDTH-1:SPLIT]),
    .b    (opb[WIDTH-1:SPLIT]),
    .cin  (hi_cin),
    .s    (hi_sum),
    .cout (hi_cy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      sum       <= '0;
      carry_out <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum       <= {hi_sum, lo_sum};
        carry_out <= hi_cy;
      end
    end
  end

endmodule

// File: rtl/sa_adder_chk.sv
module sa_adder_chk #(
  parameter int W = 8,
  parameter int K = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         exact_mode,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         out_valid,
  input logic [W-1:0] sum,
  input logic         carry_out
);

  logic [W:0]   ref_full;
  logic [K:0]   ref_low;
  logic [W-K:0] ref_hi;
  logic [W:0]   err_term;

  assign ref_full = {1'b0, opa} + {1'b0, opb};
  assign ref_low  = {1'b0, opa[K-1:0]} + {1'b0, opb[K-1:0]};
  assign ref_hi   = {1'b0, opa[W-1:K]} + {1'b0, opb[W-1:K]};
  assign err_term = ref_low[K] ? ((W+1)'(1) << K) : '0;

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(sum) && $stable(carry_out)));

  // R2
  exact_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && exact_mode) |=> ({carry_out, sum} == $past(ref_full)));

  // R3
  low_field_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (sum[K-1:0] == $past(ref_low[K-1:0])));

  // R4
  approx_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !exact_mode) |=> ({carry_out, sum[W-1:K]} == $past(ref_hi)));

  // R5
  approx_err_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !exact_mode) |=> (({carry_out, sum} + $past(err_term)) == $past(ref_full)));

endmodule

bind seg_approx_adder sa_adder_chk #(.W(WIDTH), .K(SPLIT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .exact_mode (exact_mode),
  .opa        (opa),
  .opb        (opb),
  .out_valid  (out_valid),
  .sum        (sum),
  .carry_out  (carry_out)
);

// File: tb/seg_approx_adder_test.sv
module seg_approx_adder_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int K = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         exact_mode = 1'b0;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic         out_valid;
  logic [W-1:0] sum;
  logic         carry_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [W:0] exp_q[$];
  logic [W:0] full_q[$];
  logic       mode_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_approx_adder #(.WIDTH(W), .SPLIT(K)) uut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .exact_mode (exact_mode),
    .opa        (opa),
    .opb        (opb),
    .out_valid  (out_valid),
    .sum        (sum),
    .carry_out  (carry_out)
  );

  task automatic check(input bit ok, input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Driver: presents one operation and queues its expected result.
  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic ex, input string tag);
    logic [W:0]   full;
    logic [K:0]   lo;
    logic [W-K:0] hi;
    @(negedge clk);
    opa = a; opb = b; exact_mode = ex; in_valid = 1'b1;
    full = {1'b0, a} + {1'b0, b};
    lo   = {1'b0, a[K-1:0]} + {1'b0, b[K-1:0]};
    hi   = {1'b0, a[W-1:K]} + {1'b0, b[W-1:K]};
    exp_q.push_back(ex ? full : {hi, lo[K-1:0]});
    full_q.push_back(full);
    mode_q.push_back(ex);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      opa = opa + 8'h35; opb = opb ^ 8'hA7; exact_mode = ~exact_mode;
    end
  endtask

  // Monitor: pops and compares each result as it appears.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected out_valid", {carry_out, sum}, '0);
        end else begin
          logic [W:0] e, f, d;
          logic       m;
          string      t;
          e = exp_q.pop_front(); f = full_q.pop_front();
          m = mode_q.pop_front(); t = tag_q.pop_front();
          check({carry_out, sum} == e, t, {carry_out, sum}, e);
          if (!m) begin
            d = f - {carry_out, sum};
            check(d == 9'd0 || d == 9'd16, "R5 approx error is 0 or 2^k", d, f - e);
          end
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W:0] held;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", {8'd0, out_valid}, '0);
    check({carry_out, sum} == '0, "R1 sum/carry after reset", {carry_out, sum}, '0);
    @(negedge clk);
    rst = 1'b0;

    // R8 corner vectors
    drive(8'h0F, 8'h01, 1'b0, "R8 0x0F+0x01 approx");
    drive(8'h0F, 8'h01, 1'b1, "R2 0x0F+0x01 exact");
    drive(8'hFF, 8'hFF, 1'b0, "R8 0xFF+0xFF approx");
    drive(8'hFF, 8'hFF, 1'b1, "R2 0xFF+0xFF exact");
    drive(8'h07, 8'h08, 1'b0, "R3 no low carry approx");
    drive(8'hF0, 8'h10, 1'b0, "R4 upper carry-out approx");
    drive(8'h88, 8'h88, 1'b1, "R2 both fields carry exact");
    idle(1);

    // R6: idle cycles hold sum and carry
    @(negedge clk);
    held = {carry_out, sum};
    idle(3);
    check({carry_out, sum} == held, "R6 hold during idle", {carry_out, sum}, held);
    check(out_valid == 1'b0, "R6 out_valid low when idle", {8'd0, out_valid}, '0);

    // R7: alternating modes back to back
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b;
      a = W'(i * 37 + 5);
      b = W'(i * 91 + 3);
      drive(a, b, i[0], i[0] ? "R7 R2 alternating exact" : "R7 R4 alternating approx");
    end
    idle(2);

    // Sweep: mixed patterns with gaps
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] a, b;
      a = W'(i * 13 + (i >> 3) * 7);
      b = W'(255 - i * 29);
      drive(a, b, (i % 3) == 0, ((i % 3) == 0) ? "R2 sweep exact" : "R3 R4 sweep approx");
      if ((i % 17) == 0) idle(1);
    end
    idle(4);
    check(exp_q.size() == 0, "R6 all results delivered", 9'(exp_q.size()), '0);
    finish_run();
  end

endmodule